// File: doc/BRIEF.md
# Frame-Sync Activity Power Controller

This block decides whether a voice codec is powered up or powered down, and when its serial data output may leave high impedance. All of its logic runs on a free-running timebase clock. It watches three asynchronous inputs: a dedicated power-down control pin, the transmit frame sync and the receive frame sync. It drives two flags, `pwr_down` and `dout_en`. The codec's analog sections and its output buffer use these flags.

There are two ways into power-down. The first is the control pin held at a static high level. The second is an inactivity timeout: if neither frame sync shows a rising edge for `TIMEOUT_CYCLES` timebase cycles, the block powers down. The block powers up on the first rising edge of either frame sync, but only while the pin is low or toggling. A toggling pin is a master clock running on that pin, and the block treats it like a low level. After power-up the data output stays blocked until the second transmit frame sync. Every entry into power-down clears that count.

The controller is a four-state machine:
- `PS_DOWN`: powered down.
- `PS_WAIT_FIRST`: powered up, no transmit sync seen yet.
- `PS_WAIT_SECOND`: powered up, one transmit sync seen.
- `PS_LIVE`: output allowed.

It has these transitions:
- PS_DOWN goes to PS_WAIT_SECOND on a transmit sync edge.
- PS_DOWN goes to PS_WAIT_FIRST on a receive-only sync edge.
- PS_WAIT_FIRST goes to PS_WAIT_SECOND on a transmit sync edge.
- PS_WAIT_SECOND goes to PS_LIVE on a transmit sync edge.
- Any powered state goes to PS_DOWN on a pin force or on timer expiry with no sync edge in that cycle.

Top module: `fspc_power_ctrl`

## Requirements
- R1: After reset is released, `pwr_down` is 1 and `dout_en` is 0.
- R2: A power-down pin held high with no transition for `ACT_WINDOW` cycles forces `pwr_down` to 1 and `dout_en` to 0 within a few cycles, even while frame syncs keep arriving.
- R3: When neither frame sync has a rising edge for `TIMEOUT_CYCLES` cycles, the block powers down. Before that window expires it stays powered up.
- R4: While the pin is low, the first rising edge of either frame sync powers the block up. While the pin is static high, frame sync edges do not power it up.
- R5: After power-up, `dout_en` rises only once the second transmit frame sync rising edge has been seen. Receive frame sync edges do not advance this count.
- R6: A rising edge of either frame sync restarts the inactivity window.
- R7: A pin that toggles at least once every `ACT_WINDOW` cycles counts as active and permits power-up, the same as a low level.
- R8: Entering power-down clears the transmit sync count. After the next power-up, two transmit sync edges are again needed before `dout_en` is 1.
- R9: `dout_en` is 0 in every cycle where `pwr_down` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Power-on reset, active low |
| pdn_pin | input | 1 | Power-down control pin: static high powers down; low or toggling permits power-up |
| fs_tx | input | 1 | Transmit frame sync, asynchronous |
| fs_rx | input | 1 | Receive frame sync, asynchronous |
| pwr_down | output | 1 | 1 while the block is powered down |
| dout_en | output | 1 | 1 when the serial data output may drive |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 64, `ACT_WINDOW` = 8 and two synchronizer stages. With these values the inactivity timeout and its restart on a late frame sync can be observed in under a hundred cycles. They also let a static pin be told apart from a toggling one within about a dozen cycles. This makes the timeout expiry, the two-edge output rule after each re-power-up, and the force-down over live frame syncs all reachable in a short run.

// File: rtl/fspc_pkg.sv
package fspc_pkg;
    typedef enum logic [1:0] {
        PS_DOWN        = 2'd0,
        PS_WAIT_FIRST  = 2'd1,
        PS_WAIT_SECOND = 2'd2,
        PS_LIVE        = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/fspc_sync_rise.sv
// Synchronizes an asynchronous level and flags its rising edge for one cycle.
module fspc_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] shreg;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            prev_q <= 1'b0;
        end else begin
            shreg  <= {shreg[STAGES-2:0], din};
            prev_q <= shreg[STAGES-1];
        end
    end

    assign rise = shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fspc_pin_monitor.sv
// Classifies the power-down pin: static high forces power-down; low or toggling permits power-up.
module fspc_pin_monitor #(
    parameter int STAGES     = 2,
    parameter int ACT_WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic force_down
);
    localparam int QW = $clog2(ACT_WINDOW + 1);

    logic [STAGES-1:0] shreg;
    logic              prev_q;
    logic [QW-1:0]     quiet_q;
    logic              level;
    logic              toggle;
    logic              pin_active;

    assign level  = shreg[STAGES-1];
    assign toggle = level ^ prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '1;
            prev_q <= 1'b1;
        end else begin
            shreg  <= {shreg[STAGES-2:0], pin};
            prev_q <= level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= QW'(ACT_WINDOW);
        end else if (toggle) begin
            quiet_q <= '0;
        end else if (quiet_q != QW'(ACT_WINDOW)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign pin_active = (quiet_q != QW'(ACT_WINDOW));
    assign force_down = level & ~pin_active;

    AST_TOGGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !force_down); // R7
endmodule

// File: rtl/fspc_idle_timer.sv
// Counts timebase cycles since the last frame sync edge; flags expiry at the terminal count.
module fspc_idle_timer #(
    parameter int TIMEOUT_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(TIMEOUT_CYCLES - 1);
        end else if (reload) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(TIMEOUT_CYCLES - 1));

    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !expired); // R6
endmodule

// File: rtl/fspc_power_fsm.sv
// Power state machine: power-up on sync edges, power-down on force or timeout, gates the data output.
module fspc_power_fsm
    import fspc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise,
    input  logic rx_rise,
    input  logic force_down,
    input  logic idle_expired,
    output logic pwr_down,
    output logic dout_en
);
    pwr_state_e state_q, state_d;
    logic       any_rise;
    logic       go_down;

    assign any_rise = tx_rise | rx_rise;
    assign go_down  = force_down | (idle_expired & ~any_rise);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_DOWN: begin
                if (!force_down && tx_rise)      state_d = PS_WAIT_SECOND;
                else if (!force_down && rx_rise) state_d = PS_WAIT_FIRST;
            end
            PS_WAIT_FIRST: begin
                if (go_down)      state_d = PS_DOWN;
                else if (tx_rise) state_d = PS_WAIT_SECOND;
            end
            PS_WAIT_SECOND: begin
                if (go_down)      state_d = PS_DOWN;
                else if (tx_rise) state_d = PS_LIVE;
            end
            PS_LIVE: begin
                if (go_down) state_d = PS_DOWN;
            end
            default: state_d = PS_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        pwr_down = (state_q == PS_DOWN);
        dout_en  = (state_q == PS_LIVE);
    end

    AST_FORCE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        force_down |=> pwr_down); // R2
    AST_IDLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_expired && !any_rise) |=> pwr_down); // R3
    AST_WAKE_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_down && any_rise) |=> !pwr_down); // R4
    AST_DOUT_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(tx_rise)); // R5
    AST_WAKE_BLOCKS_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !dout_en); // R8
endmodule

// File: rtl/fspc_power_ctrl.sv
module fspc_power_ctrl #(
    parameter int TIMEOUT_CYCLES = 4096,
    parameter int ACT_WINDOW     = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_pin,
    input  logic fs_tx,
    input  logic fs_rx,
    output logic pwr_down,
    output logic dout_en
);
    logic tx_rise, rx_rise, force_down, idle_expired;

    fspc_sync_rise #(.STAGES(SYNC_STAGES)) u_tx (
        .clk(clk), .rst_n(rst_n), .din(fs_tx), .rise(tx_rise));

    fspc_sync_rise #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .din(fs_rx), .rise(rx_rise));

    fspc_pin_monitor #(.STAGES(SYNC_STAGES), .ACT_WINDOW(ACT_WINDOW)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin(pdn_pin), .force_down(force_down));

    fspc_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .reload(tx_rise | rx_rise), .expired(idle_expired));

    fspc_power_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_rise(tx_rise), .rx_rise(rx_rise),
        .force_down(force_down), .idle_expired(idle_expired),
        .pwr_down(pwr_down), .dout_en(dout_en));

    AST_DOWN_NO_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !dout_en); // R9
endmodule

// File: tb/fspc_power_ctrl_test.sv
module fspc_power_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 64;
    localparam int WIN        = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_pin = 1'b1;
    logic fs_tx = 1'b0;
    logic fs_rx = 1'b0;
    logic tog_en = 1'b0;
    logic pwr_down, dout_en;
    int   checks = 0;
    int   errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (tog_en) pdn_pin <= ~pdn_pin;

    fspc_power_ctrl #(.TIMEOUT_CYCLES(TMO), .ACT_WINDOW(WIN), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .pdn_pin(pdn_pin), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .pwr_down(pwr_down), .dout_en(dout_en));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        @(negedge clk); fs_tx = 1'b1;
        wait_cyc(2);    fs_tx = 1'b0;
        wait_cyc(6);
    endtask

    task automatic pulse_rx();
        @(negedge clk); fs_rx = 1'b1;
        wait_cyc(2);    fs_rx = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        wait_cyc(2);
        chk("R1 pwr_down", pwr_down, 1'b1);
        chk("R1 dout_en", dout_en, 1'b0);
    endtask

    task automatic t_pin_high_blocks();
        pdn_pin = 1'b1;
        wait_cyc(WIN + 6);
        pulse_tx();
        chk("R4 no wake with pin high", pwr_down, 1'b1);
        pulse_rx();
        chk("R2 pin high keeps down", pwr_down, 1'b1);
    endtask

    task automatic t_wake_rx_then_tx();
        pdn_pin = 1'b0;
        wait_cyc(4);
        pulse_rx();
        chk("R4 wake on rx", pwr_down, 1'b0);
        chk("R5 dout blocked after wake", dout_en, 1'b0);
        pulse_rx();
        chk("R5 rx does not count", dout_en, 1'b0);
        pulse_tx();
        chk("R5 first tx still blocked", dout_en, 1'b0);
        pulse_tx();
        chk("R5 second tx enables", dout_en, 1'b1);
    endtask

    task automatic t_timeout();
        wait_cyc(40);
        chk("R3 still up before window", pwr_down, 1'b0);
        wait_cyc(50);
        chk("R3 down after idle window", pwr_down, 1'b1);
        chk("R9 dout off when down", dout_en, 1'b0);
    endtask

    task automatic t_rewake_and_reload();
        pulse_tx();
        chk("R4 wake on tx", pwr_down, 1'b0);
        chk("R8 count cleared after down", dout_en, 1'b0);
        wait_cyc(40);
        pulse_rx();
        wait_cyc(40);
        chk("R6 rx edge restarts window", pwr_down, 1'b0);
        pulse_tx();
        chk("R8 second tx after rewake", dout_en, 1'b1);
    endtask

    task automatic t_pin_force();
        pdn_pin = 1'b1;
        for (int i = 0; i < 3; i++) pulse_tx();
        chk("R2 forced down despite syncs", pwr_down, 1'b1);
        chk("R9 dout off on force", dout_en, 1'b0);
    endtask

    task automatic t_toggle();
        tog_en = 1'b1;
        wait_cyc(4);
        pulse_tx();
        chk("R7 toggling pin permits wake", pwr_down, 1'b0);
        pulse_tx();
        chk("R7 dout after two tx while toggling", dout_en, 1'b1);
        tog_en = 1'b0;
        @(negedge clk); pdn_pin = 1'b1;
        wait_cyc(WIN + 8);
        chk("R2 static high after toggling", pwr_down, 1'b1);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_pin_high_blocks();
        t_wake_rx_then_tx();
        t_timeout();
        t_rewake_and_reload();
        t_pin_force();
        t_toggle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule